// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out buffer, 64 words deep and 9 bits wide by default, whose writer and reader each use a single strobe line instead of a clocked enable. The writer raises its strobe to capture the input word and lowers it to send that word on toward the output. The reader raises its strobe to acknowledge the word it sees and lowers it to ask for the next one. A system clock samples both strobes through a synchronizer and acts on their edges, so the two sides may toggle their strobes at any rate slower than the internal transfer.

A word written into an empty buffer falls through to a separate output register by itself, without any read request. Two flags guide the handshake. The input flag says the input stage can take a word. The output flag says the output register holds a valid word that has not yet been acknowledged. An active-low reset clears all control state but leaves the output register as it was. An active-low output enable decides whether the data bus is driven or left at high impedance. None of the data bits has a fixed weight.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low, `in_ready` reads 1 and `out_ready` reads 0 from the next clock edge on. Words held before reset are discarded, so `out_ready` stays 0 after release until a new word is written.
- R2: Reset leaves the output register unchanged. With `oe_n` low, `dout` keeps showing the last word loaded into it through and after reset.
- R3: The block holds at most DEPTH (64) words, counting the output register. With DEPTH words held, `in_ready` is 0 and shift-in strobes have no effect.
- R4: A rising edge of `si` while `in_ready` is 1 captures `din`. `in_ready` then reads 0 until the transfer started by the next falling edge of `si` has finished.
- R5: When a word is written into an empty block, it appears on `dout` and `out_ready` rises within 5 clock edges of the falling edge of `si`. `out_ready` is never 1 before the output register holds that word.
- R6: Words leave in the order they were written, with all bits unchanged.
- R7: A rising edge of `so` while `out_ready` is 1 drives `out_ready` to 0 within 3 clock edges. The falling edge that follows replaces the output word with the next stored word, if there is one.
- R8: A rising edge of `so` while `out_ready` is 0 has no effect on later transfers.
- R9: If `si` is high while reset is released, the `din` present at release is captured as a write.
- R10: While `oe_n` is 1, `dout_drv` is 0 and `dout` is high impedance. While `oe_n` is 0, `dout_drv` is 1 and `dout` carries the output register.
- R11: The output register does not change while `out_ready` stays 1, including while a shift-out strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low master reset, synchronous |
| si | input | 1 | Shift-in strobe: rising edge captures, falling edge transfers |
| so | input | 1 | Shift-out strobe: rising edge acknowledges, falling edge advances |
| oe_n | input | 1 | Active-low output enable for the data bus |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data; high impedance while disabled |
| dout_drv | output | 1 | 1 while `dout` is driven |
| in_ready | output | 1 | Input stage free and buffer not full |
| out_ready | output | 1 | Valid, unacknowledged word on the output register |

## Verification
A wrong occupancy count shows first at `in_ready`. The flag drops a word too early or too late on a full sweep, or an extra word slips in past the limit and comes out ahead of its turn in the read order. A stuck or missed strobe edge shows within a few clock edges as a flag that does not change, and the bench samples a fixed number of cycles after each strobe. A bad read pointer or a late fill shows on the next word read as wrong data or wrong order. A register cleared by reset shows at once on `dout` while the block is still in reset.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

   // One-cycle edge events produced by a strobe synchronizer
   typedef struct packed {
      logic rise;
      logic fall;
   } strobe_evt_t;

   // Address width for a storage of the given depth, never below one bit
   function automatic int addr_bits(input int depth);
      return (depth > 2) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync
   import strobe_fifo_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strobe,
   output strobe_evt_t evt
);

   if (STAGES < 2) begin : g_bad_stages
      $error("strobe_edge_sync: STAGES must be at least 2");
   end

   // chain[0..STAGES-1] synchronize, chain[STAGES] remembers the prior level
   logic [STAGES:0] chain;

   for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= strobe;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign evt.rise = chain[STAGES-1] & ~chain[STAGES];
   assign evt.fall = ~chain[STAGES-1] & chain[STAGES];

endmodule

// File: rtl/strobe_fifo_store.sv
module strobe_fifo_store
   import strobe_fifo_pkg::*;
#(
   parameter int WIDTH = 9,
   parameter int DEPTH = 64,
   localparam int PTR_W = addr_bits(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic [CNT_W-1:0] count
);

   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign pop_data = mem[rd_ptr];

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
   import strobe_fifo_pkg::*;
#(
   parameter int WIDTH       = 9,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             si,
   input  logic             so,
   input  logic             oe_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             dout_drv,
   output logic             in_ready,
   output logic             out_ready
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

   if (WIDTH < 1) begin : g_bad_width
      $error("strobe_fifo: WIDTH must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("strobe_fifo: DEPTH must be at least 2");
   end

   strobe_evt_t si_evt;
   strobe_evt_t so_evt;

   strobe_edge_sync #(.STAGES(SYNC_STAGES)) si_sync_i (
      .clk(clk), .rst_n(rst_n), .strobe(si), .evt(si_evt)
   );
   strobe_edge_sync #(.STAGES(SYNC_STAGES)) so_sync_i (
      .clk(clk), .rst_n(rst_n), .strobe(so), .evt(so_evt)
   );

   // Input stage
   logic             in_busy;
   logic [WIDTH-1:0] in_word;
   // Output stage
   logic             out_full;
   logic             out_busy;
   logic [WIDTH-1:0] q_reg;
   // Storage
   logic             push;
   logic             pop;
   logic [WIDTH-1:0] pop_data;
   logic [CNT_W-1:0] store_cnt;
   logic [CNT_W-1:0] total_words;

   assign total_words = store_cnt + CNT_W'(out_full);
   assign in_ready    = !in_busy && (total_words < FULL_C);
   assign out_ready   = out_full && !out_busy;

   assign push = si_evt.fall && in_busy;
   assign pop  = !out_full && (store_cnt != '0);

   strobe_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_data(in_word),
      .pop(pop), .pop_data(pop_data),
      .count(store_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_busy  <= 1'b0;
         out_full <= 1'b0;
         out_busy <= 1'b0;
      end else begin
         if (si_evt.rise && in_ready) in_busy <= 1'b1;
         else if (push)               in_busy <= 1'b0;

         if (so_evt.rise && out_ready) out_busy <= 1'b1;

         if (so_evt.fall && out_busy) begin
            out_full <= 1'b0;
            out_busy <= 1'b0;
         end else if (pop) begin
            out_full <= 1'b1;
         end
      end
   end

   // Data registers carry no reset: the output word survives master reset
   always_ff @(posedge clk) begin
      if (rst_n && si_evt.rise && in_ready) in_word <= din;
   end

   always_ff @(posedge clk) begin
      if (rst_n && pop) q_reg <= pop_data;
   end

   assign dout_drv = !oe_n;
   assign dout     = dout_drv ? q_reg : {WIDTH{1'bz}};

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 64,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_ready,
   input logic             out_ready,
   input logic [WIDTH-1:0] q_reg,
   input logic [CNT_W-1:0] total_words
);

   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

   assert_reset_flags_R1: assert property (@(posedge clk)
      !rst_n |=> (in_ready && !out_ready));

   assert_reset_keeps_q_R2: assert property (@(posedge clk)
      !rst_n |=> $stable(q_reg));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      total_words <= FULL_C);

   assert_ready_has_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_ready) |-> (total_words != '0));

   assert_hold_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && $past(out_ready)) |-> $stable(q_reg));

endmodule

bind strobe_fifo strobe_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
   .clk(clk),
   .rst_n(rst_n),
   .in_ready(in_ready),
   .out_ready(out_ready),
   .q_reg(q_reg),
   .total_words(total_words)
);

// File: tb/strobe_fifo_tb_top.sv
`timescale 1ns/1ps
module strobe_fifo_tb_top;

   localparam int W = 9;
   localparam int D = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         si = 1'b0;
   logic         so = 1'b0;
   logic         oe_n = 1'b0;
   logic [W-1:0] din = '0;
   wire  [W-1:0] dout;
   wire          dout_drv;
   wire          in_ready;
   wire          out_ready;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   strobe_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .si(si), .so(so), .oe_n(oe_n),
      .din(din), .dout(dout), .dout_drv(dout_drv),
      .in_ready(in_ready), .out_ready(out_ready)
   );

   function automatic logic [W-1:0] pattern(input int i);
      return W'((i * 37 + 5) % (1 << W));
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input bit ok, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push_word(input logic [W-1:0] d);
      din = d;
      si  = 1'b1;
      cyc(4);
      si  = 1'b0;
      cyc(6);
   endtask

   // Reads the current word, checks flag drop and hold while acknowledged
   task automatic pop_word(output logic [W-1:0] got);
      got = dout;
      so  = 1'b1;
      cyc(4);
      check("R7 out_ready low after so rise", out_ready == 1'b0, out_ready, 0);
      check("R11 dout held while acknowledged", dout == got, dout, got);
      so  = 1'b0;
      cyc(6);
   endtask

   initial begin
      logic [W-1:0] got;
      int k;
      int seen;
      int bad;

      // Reset state
      cyc(3);
      check("R1 in_ready in reset", in_ready == 1'b1, in_ready, 1);
      check("R1 out_ready in reset", out_ready == 1'b0, out_ready, 0);
      rst_n = 1'b1;
      cyc(2);

      // Fall-through latency into an empty block
      din = 9'h0A5;
      si  = 1'b1;
      cyc(3);
      check("R4 in_ready low after capture", in_ready == 1'b0, in_ready, 0);
      din = 9'h111;
      si  = 1'b0;
      seen = 0;
      for (int c = 1; c <= 8; c++) begin
         cyc(1);
         if (seen == 0 && out_ready) begin
            seen = c;
            check("R5 word present when flag rises", dout == 9'h0A5, dout, 9'h0A5);
         end
      end
      check("R5 fall-through within 5 edges", seen >= 1 && seen <= 5, seen, 5);
      check("R4 in_ready back after transfer", in_ready == 1'b1, in_ready, 1);
      pop_word(got);
      check("R6 single word data", got == 9'h0A5, got, 9'h0A5);
      check("R7 empty after last read", out_ready == 1'b0, out_ready, 0);

      // Shift-out while nothing is ready must be ignored
      so = 1'b1; cyc(4); so = 1'b0; cyc(6);
      push_word(9'h1C3);
      check("R8 word ready after ignored shift-out", out_ready == 1'b1, out_ready, 1);
      pop_word(got);
      check("R8 data after ignored shift-out", got == 9'h1C3, got, 9'h1C3);

      // Fill to capacity, overflow attempt, then drain in order
      bad = 0;
      for (int i = 0; i < D; i++) begin
         if (!in_ready) bad++;
         push_word(pattern(i));
      end
      check("R3 ready until full", bad == 0, bad, 0);
      check("R3 in_ready low when full", in_ready == 1'b0, in_ready, 0);
      push_word(9'h1AA);
      check("R3 still full after ignored write", in_ready == 1'b0, in_ready, 0);
      for (int i = 0; i < D; i++) begin
         check("R7 word ready for read", out_ready == 1'b1, out_ready, 1);
         pop_word(got);
         check("R6 order after full sweep", got == pattern(i), got, pattern(i));
      end
      check("R3 no extra word after drain", out_ready == 1'b0, out_ready, 0);
      check("R3 ready after drain", in_ready == 1'b1, in_ready, 1);

      // Output enable
      push_word(9'h05A);
      oe_n = 1'b1; cyc(1);
      check("R10 bus released", dout_drv == 1'b0, dout_drv, 0);
      oe_n = 1'b0; cyc(1);
      check("R10 bus driven", dout_drv == 1'b1, dout_drv, 1);
      check("R10 driven data", dout == 9'h05A, dout, 9'h05A);

      // Reset keeps output word and discards stored ones
      push_word(9'h133);
      rst_n = 1'b0; cyc(3);
      check("R1 in_ready during reset", in_ready == 1'b1, in_ready, 1);
      check("R1 out_ready during reset", out_ready == 1'b0, out_ready, 0);
      check("R2 output kept in reset", dout == 9'h05A, dout, 9'h05A);
      rst_n = 1'b1; cyc(8);
      check("R1 contents discarded", out_ready == 1'b0, out_ready, 0);
      check("R2 output kept after reset", dout == 9'h05A, dout, 9'h05A);

      // Shift-in held high across reset release
      din = 9'h0E7; si = 1'b1; rst_n = 1'b0; cyc(3);
      rst_n = 1'b1; cyc(5);
      din = 9'h018; si = 1'b0; cyc(8);
      check("R9 word loaded at release", out_ready == 1'b1, out_ready, 1);
      check("R9 release data", dout == 9'h0E7, dout, 9'h0E7);
      pop_word(got);

      // Interleaved bursts of growing length
      k = 100;
      for (int n = 1; n <= 6; n++) begin
         for (int j = 0; j < n; j++) push_word(pattern(k + j));
         for (int j = 0; j < n; j++) begin
            pop_word(got);
            check("R6 burst order", got == pattern(k + j), got, pattern(k + j));
         end
         k += n;
      end
      check("R6 empty after bursts", out_ready == 1'b0, out_ready, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule